// File: doc/BRIEF.md
# Breakpoint Graph Weight Builder

This block turns three signed gene orders into the edge-weight table of a complete graph that a later tour search can read. Each gene `g` (1 to N) becomes two vertices, one for its plus end and one for its minus end, so the graph has 2N vertices. Every ordinary edge starts at weight 3. Each time one genome shows gene `x` directly followed by gene `y`, the edge between vertex `-x` and vertex `y` loses one unit. An adjacency that all three genomes share therefore ends at 0. The edge between the two ends of one gene holds a reserved minus-infinity code that never changes.

A start pulse first rewrites the table to its initial values, one row per cycle. The block then accepts genes one per cycle on a valid/ready stream, with a flag on the last gene of each genome. Genomes are linear: the last gene is not linked back to the first, and no adjacency spans two genomes. After the third genome ends, `done` rises and the table is read through a combinational random-access port. Vertex index `2*(g-1)` names `+g` and `2*(g-1)+1` names `-g`.

Top module: `bp_weight_table`

## Requirements
- R1: After reset, `done` and `in_ready` are both 0 until a start pulse is given.
- R2: A start pulse holds `in_ready` low for exactly 2N cycles while the table is rewritten, then raises it.
- R3: After the rewrite, every edge between vertices of two different genes reads 3 until an adjacency touches it.
- R4: An entry whose two vertices belong to the same gene (including the diagonal) reads the most negative code of the weight width (-8 for 4 bits), and it is never changed.
- R5: An accepted gene `y` that directly follows gene `x` in the same genome lowers the weight between vertex index of `-x` and vertex index of `y` by one. Vertex index is `2*(g-1)` for `+g` and `2*(g-1)+1` for `-g`, and the sign of `x` is flipped to form `-x`.
- R6: The table is symmetric: reading (a,b) and (b,a) always returns the same value.
- R7: Genomes are linear: no weight changes between the last gene of a genome and its first, nor between the last gene of one genome and the first gene of the next.
- R8: A weight never drops below 0. A decrement of an entry already at 0 leaves it at 0.
- R9: `done` rises in the cycle after the third gene flagged last is accepted. From then on `in_ready` stays low and `done` stays high until the next start.
- R10: A start pulse given while genomes are being loaded discards all loaded adjacencies and the genome count. The following three genomes build the table from scratch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a new build: rewrite the table and reset the genome count |
| in_valid | input | 1 | A gene is offered |
| in_ready | output | 1 | The block accepts a gene this cycle |
| in_gene | input | $clog2(N+1) | Gene number, 1 to N |
| in_neg | input | 1 | Gene sign, 1 for minus |
| in_last | input | 1 | This gene ends the current genome |
| done | output | 1 | All three genomes consumed, table complete |
| rd_a | input | $clog2(2N) | Read port, first vertex index |
| rd_b | input | $clog2(2N) | Read port, second vertex index |
| rd_w | output | WW | Signed weight of edge (rd_a, rd_b) |

## Verification
Two events can fall in the same cycle: the decrement caused by the final gene of the third genome, and the change of state that raises `done` and drops `in_ready`. The bench sends every genome back to back with no idle cycles, so the last adjacency and the end of the build always coincide. It then checks that `done` is high exactly one cycle later and that the final adjacency is present in the table. The same back-to-back stream puts one genome's last gene directly before the next genome's first gene, and reading that pair's entry shows whether a false adjacency was formed. A start pulse raised while a gene is being offered is a second such collision, and the table built afterwards must show no trace of the abandoned genome.

// File: rtl/bp_weight_table.sv
module bp_weight_table #(
  parameter int N  = 8,
  parameter int WW = 4,
  localparam int VN = 2 * N,
  localparam int VW = $clog2(VN),
  localparam int GW = $clog2(N + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [GW-1:0]        in_gene,
  input  logic                 in_neg,
  input  logic                 in_last,
  output logic                 done,
  input  logic [VW-1:0]        rd_a,
  input  logic [VW-1:0]        rd_b,
  output logic signed [WW-1:0] rd_w
);
  localparam logic signed [WW-1:0] W_INIT = WW'(3);
  localparam logic signed [WW-1:0] W_NEG  = {1'b1, {(WW-1){1'b0}}};

  typedef enum logic [1:0] {S_IDLE, S_CLR, S_LOAD, S_DONE} st_t;
  st_t st;

  logic signed [WW-1:0] tbl [VN][VN];
  logic [VW-1:0] row, prev_v, cur_v;
  logic [1:0]    gcnt;
  logic          have_prev, acc, dec;
  logic signed [WW-1:0] w_cur;

  assign in_ready = (st == S_LOAD);
  assign done     = (st == S_DONE);
  assign acc      = in_valid && in_ready && !start;
  assign cur_v    = VW'(2 * (int'(in_gene) - 1)) | VW'(in_neg);
  assign w_cur    = tbl[prev_v][cur_v];
  assign dec      = acc && have_prev && (prev_v[VW-1:1] != cur_v[VW-1:1]) && (w_cur > 0);
  assign rd_w     = tbl[rd_a][rd_b];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      row       <= '0;
      prev_v    <= '0;
      have_prev <= 1'b0;
      gcnt      <= '0;
    end else if (start) begin
      st        <= S_CLR;
      row       <= '0;
      have_prev <= 1'b0;
      gcnt      <= '0;
    end else begin
      case (st)
        S_CLR: begin
          row <= row + 1'b1;
          if (int'(row) == VN - 1) st <= S_LOAD;
        end
        S_LOAD: if (acc) begin
          prev_v    <= cur_v ^ VW'(1);
          have_prev <= !in_last;
          if (in_last) begin
            gcnt <= gcnt + 1'b1;
            if (gcnt == 2'd2) st <= S_DONE;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (st == S_CLR) begin
      for (int j = 0; j < VN; j++)
        tbl[row][j] <= ((int'(row) >> 1) == (j >> 1)) ? W_NEG : W_INIT;
    end else if (dec) begin
      tbl[prev_v][cur_v] <= w_cur - WW'(1);
      tbl[cur_v][prev_v] <= w_cur - WW'(1);
    end
  end
endmodule

module bp_weight_table_chk #(
  parameter int N  = 8,
  parameter int WW = 4,
  localparam int VW = $clog2(2 * N)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 start,
  input logic                 in_ready,
  input logic                 done,
  input logic [VW-1:0]        rd_a,
  input logic [VW-1:0]        rd_b,
  input logic signed [WW-1:0] rd_w
);
  localparam logic signed [WW-1:0] W_NEG = {1'b1, {(WW-1){1'b0}}};

  // R2
  start_blocks_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !in_ready);

  // R9
  done_excludes_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !in_ready);

  // R9
  done_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);

  // R4
  own_pair_marker_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && rd_a[VW-1:1] == rd_b[VW-1:1]) |-> (rd_w == W_NEG));

  // R8
  weight_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && rd_a[VW-1:1] != rd_b[VW-1:1]) |-> (rd_w >= 0 && rd_w <= 3));
endmodule

bind bp_weight_table bp_weight_table_chk #(.N(N), .WW(WW)) u_chk (.*);

// File: tb/tb_bp_weight_table.sv
`timescale 1ns/1ps
module tb_bp_weight_table;
  localparam int N = 8, WW = 4, VN = 2 * N;
  localparam int VW = $clog2(VN), GW = $clog2(N + 1);

  logic clk = 0, rst_n = 0, start = 0, in_valid = 0, in_neg = 0, in_last = 0;
  logic [GW-1:0] in_gene = '0;
  logic [VW-1:0] rd_a = '0, rd_b = '0;
  logic in_ready, done;
  logic signed [WW-1:0] rd_w;

  int tests = 0, fails = 0;
  int exp_t [VN][VN];
  int g1 [N], g2 [N], g3 [N];

  always #5 clk = ~clk;

  bp_weight_table #(.N(N), .WW(WW)) dut (.*);

  function automatic int vidx(int s);
    return 2 * ((s < 0 ? -s : s) - 1) + (s < 0 ? 1 : 0);
  endfunction

  task automatic chk(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic void model_clear();
    for (int a = 0; a < VN; a++)
      for (int b = 0; b < VN; b++)
        exp_t[a][b] = ((a >> 1) == (b >> 1)) ? -8 : 3;
  endfunction

  function automatic void model_genome(int g [N]);
    for (int i = 1; i < N; i++) begin
      int a = vidx(-g[i-1]);
      int b = vidx(g[i]);
      if ((a >> 1) != (b >> 1) && exp_t[a][b] > 0) begin
        exp_t[a][b]--;
        if (a != b) exp_t[b][a]--;
      end
    end
  endfunction

  function automatic void shuffle(ref int g [N]);
    for (int i = 0; i < N; i++) g[i] = i + 1;
    for (int i = N - 1; i > 0; i--) begin
      int j = $urandom_range(i, 0);
      int t = g[i];
      g[i] = g[j]; g[j] = t;
    end
    for (int i = 0; i < N; i++) if ($urandom_range(1, 0) == 1) g[i] = -g[i];
  endfunction

  task automatic read_w(int a, int b, output int w);
    @(negedge clk);
    rd_a = VW'(a); rd_b = VW'(b);
    #1 w = int'(rd_w);
  endtask

  task automatic do_start();
    int lows = 0;
    @(negedge clk);
    start = 1;
    @(negedge clk);
    start = 0;
    while (!in_ready && lows < 4 * VN) begin
      lows++;
      @(negedge clk);
    end
    chk("R2 ready-low cycles after start", lows, VN);
    model_clear();
  endtask

  task automatic send(int g [N]);
    for (int i = 0; i < N; i++) begin
      in_valid = 1;
      in_gene  = GW'(g[i] < 0 ? -g[i] : g[i]);
      in_neg   = g[i] < 0;
      in_last  = (i == N - 1);
      @(negedge clk);
    end
    in_valid = 0; in_last = 0;
  endtask

  task automatic send3(int a [N], int b [N], int c [N]);
    @(negedge clk);
    send(a); send(b); send(c);
    chk("R9 done after third last", int'(done), 1);
    chk("R9 ready low when done", int'(in_ready), 0);
    model_genome(a); model_genome(b); model_genome(c);
  endtask

  task automatic cmp_table(string tag);
    int bad = 0;
    for (int a = 0; a < VN; a++)
      for (int b = 0; b < VN; b++) begin
        int w, wr;
        read_w(a, b, w);
        read_w(b, a, wr);
        if (w != exp_t[a][b] && bad < 4) begin
          bad++;
          chk(((a >> 1) == (b >> 1)) ? "R4 own-pair entry" :
              (exp_t[a][b] == 3 ? "R3 untouched entry" : "R5 decremented entry"), w, exp_t[a][b]);
        end
        if (w != wr && bad < 4) begin
          bad++;
          chk("R6 symmetry", wr, w);
        end
      end
    chk({tag, " table mismatches (R5)"}, bad, 0);
  endtask

  initial begin
    #1_000_000;
    fails++; tests++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int w;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk("R1 done after reset", int'(done), 0);
    chk("R1 ready after reset", int'(in_ready), 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk("R1 ready idle before start", int'(in_ready), 0);

    // directed: identity in all three -> shared adjacencies reach 0, no wrap
    for (int i = 0; i < N; i++) begin g1[i] = i + 1; g2[i] = i + 1; g3[i] = i + 1; end
    do_start();
    read_w(vidx(-1), vidx(2), w);
    chk("R3 fresh entry", w, 3);
    read_w(vidx(1), vidx(-1), w);
    chk("R4 fresh own pair", w, -8);
    send3(g1, g2, g3);
    read_w(vidx(-1), vidx(2), w);
    chk("R5 shared adjacency reaches 0", w, 0);
    read_w(vidx(-N), vidx(1), w);
    chk("R7 no wrap or boundary adjacency", w, 3);
    cmp_table("identity");

    // directed sign case: -1 then +2 touches +1 and +2
    for (int i = 0; i < N; i++) begin g1[i] = i + 1; g2[i] = -(N - i); g3[i] = i + 1; end
    g1[0] = -1;
    do_start();
    send3(g1, g2, g3);
    read_w(vidx(1), vidx(2), w);
    chk("R5 signed adjacency -1,+2", w, 2);
    cmp_table("signed");

    // floor at zero with repeated pattern +1 +2 +1 +2 ...
    for (int i = 0; i < N; i++) begin g1[i] = (i % 2) + 1; g2[i] = (i % 2) + 1; g3[i] = (i % 2) + 1; end
    do_start();
    send3(g1, g2, g3);
    read_w(vidx(-1), vidx(2), w);
    chk("R8 floor at zero", w, 0);
    cmp_table("floor");

    // restart mid-load: partial genome discarded
    shuffle(g1);
    do_start();
    @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      in_valid = 1; in_gene = GW'(g1[i] < 0 ? -g1[i] : g1[i]); in_neg = g1[i] < 0; in_last = 0;
      @(negedge clk);
    end
    start = 1;
    @(negedge clk);
    start = 0; in_valid = 0;
    begin
      int lows = 0;
      while (!in_ready && lows < 4 * VN) begin lows++; @(negedge clk); end
      chk("R10 restart clear length", lows, VN);
    end
    model_clear();
    for (int i = 0; i < N; i++) begin g1[i] = N - i; g2[i] = -(i + 1); g3[i] = N - i; end
    send3(g1, g2, g3);
    cmp_table("restart R10");
    @(negedge clk);
    chk("R9 done held", int'(done), 1);

    // random signed permutations
    for (int t = 0; t < 8; t++) begin
      shuffle(g1); shuffle(g2); shuffle(g3);
      do_start();
      send3(g1, g2, g3);
      cmp_table("random");
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule